// File: doc/BRIEF.md
# Differential Fault Key-Byte Solver

This block recovers the bytes of the final AES round key from a stream of ciphertext pairs. Each pair holds the correct ciphertext and a faulty ciphertext produced with the same key and plaintext after a fault was injected into the state just before the last SubBytes step. Because no MixColumns follows that point, every ciphertext position can be solved on its own. Each byte lane compares its two bytes, reports how many bits differ, and, for any lane whose bytes differ, walks all 256 state values over 256 cycles. A key value becomes a candidate when some state value `x` and some single-bit error `e` give S(x) XOR S(x XOR e) equal to the observed difference, the key value being the correct byte XOR S(x).

Successive candidate sets for a lane are combined: the lane keeps the intersection when it is non-empty and otherwise takes the union, so a pair whose fault was not really a single bit does not wipe out the true key. A lane stops as soon as its set holds one value, which is then presented as the recovered key byte. If a programmable number of sets has been merged without reaching one value, the lane raises an unresolved flag and stops instead. The lane index is the ciphertext byte position, so the recovered byte belongs to the key at that same position.

Top module: `dfa_keybyte_solver`

## Requirements
- R1: After reset, `pair_ready` is 1, and every lane shows `key_valid` 0, `unresolved` 0, `key_byte` 0 and fault class 0.
- R2: On acceptance, lane i (bits 8i+7..8i of the ciphertext buses, bits 2i+1..2i of `fault_class`) reports the popcount of the XOR of its two bytes as 0 -> 2'b00, 1 -> 2'b01, 2 -> 2'b10, 3 or more -> 2'b11; the value appears the cycle after acceptance and holds until the next acceptance.
- R3: A pair is accepted on a clock edge where `pair_valid` and `pair_ready` are both 1; `pair_ready` is then 0 for exactly 257 cycles, and `pair_valid` and the buses are ignored while it is 0.
- R4: For a lane whose bytes differ by d, the new candidate set holds key value k exactly when some x in 0..255 and some bit j in 0..7 satisfy S(x) XOR S(x XOR 2^j) = d and k = good XOR S(x), S being the AES S-box.
- R5: A lane whose two bytes are equal adds no set and its merged-set count does not advance; the first set from a lane with differing bytes becomes its accumulated set as is.
- R6: Each later set replaces the accumulated set by their intersection when that is non-empty, and by their union otherwise.
- R7: When the accumulated set holds exactly one value, `key_valid` rises with `key_byte` equal to that value, in the same cycle `pair_ready` returns to 1, and both hold until reset whatever pairs follow.
- R8: When the MAX_SETS-th merged set leaves more than one value (or none), `unresolved` rises, `key_valid` stays 0, and the lane ignores later pairs until reset.
- R9: Each lane's class, set, key and flags depend only on its own bytes.
- R10: `key_byte` of a lane reads 0 while its `key_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pair_valid | input | 1 | A ciphertext pair is offered |
| pair_ready | output | 1 | Solver is idle and accepts a pair |
| ct_good | input | 8*NBYTES | Correct ciphertext, lane i in bits 8i+7..8i |
| ct_bad | input | 8*NBYTES | Faulty ciphertext, same lane layout |
| fault_class | output | 2*NBYTES | Per-lane difference weight class |
| key_valid | output | NBYTES | Per-lane key byte recovered |
| key_byte | output | 8*NBYTES | Per-lane recovered key byte |
| unresolved | output | NBYTES | Per-lane set limit reached without a single candidate |

## Verification
On every cycle the assertions check that a recovered key byte never changes, that the recovered and unresolved flags of a lane never coexist, that the accumulated set moves only in the merge cycle, that an unfaulted lane builds no candidates, and that the busy window after acceptance lasts exactly 257 cycles. Whether the candidate search, the intersect-or-union rule and the set limit produce the right key values can only be shown by the bench's scenarios, which model the whole campaign with an independently computed S-box: mixed single-bit, double-bit, wrong and absent faults across lanes, junk offered while busy, and a repeated pair that can never shrink below two candidates.

// File: rtl/dfa_pkg.sv
package dfa_pkg;

  localparam int BYTE_W = 8;
  localparam int NVAL   = 256;

  typedef enum logic [1:0] {
    FC_NONE  = 2'd0,
    FC_ONE   = 2'd1,
    FC_TWO   = 2'd2,
    FC_MULTI = 2'd3
  } fclass_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SCAN  = 2'd1,
    PH_MERGE = 2'd2
  } phase_t;

  // multiply by the field generator modulo the AES polynomial
  function automatic logic [7:0] gf_x2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_x2(sh);
    end
    return acc;
  endfunction

  function automatic fclass_t weigh(input logic [7:0] d);
    logic [3:0] w;
    w = 4'($countones(d));
    if (w == 4'd0)      return FC_NONE;
    else if (w == 4'd1) return FC_ONE;
    else if (w == 4'd2) return FC_TWO;
    else                return FC_MULTI;
  endfunction

endpackage

// File: rtl/dfa_sbox.sv
module dfa_sbox
  import dfa_pkg::*;
(
  input  logic [7:0] a_i,
  output logic [7:0] y_o
);

  logic [7:0] p2, p4, p8, p16, p32, p64, p128;
  logic [7:0] inv;

  // inverse as a^254, 254 = 2+4+8+16+32+64+128 (0 maps to 0)
  always_comb begin
    p2   = gf_mul(a_i, a_i);
    p4   = gf_mul(p2, p2);
    p8   = gf_mul(p4, p4);
    p16  = gf_mul(p8, p8);
    p32  = gf_mul(p16, p16);
    p64  = gf_mul(p32, p32);
    p128 = gf_mul(p64, p64);
    inv  = gf_mul(gf_mul(gf_mul(p128, p64), gf_mul(p32, p16)),
                  gf_mul(gf_mul(p8, p4), p2));
    y_o  = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
               ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  end

endmodule

// File: rtl/dfa_probe.sv
module dfa_probe
  import dfa_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic [7:0]            x_i,
  output logic [7:0]            sx_o,
  output logic [NBITS-1:0][7:0] diff_o
);

  logic [NBITS-1:0][7:0] sflip;

  dfa_sbox u_sbase (.a_i(x_i), .y_o(sx_o));

  for (genvar j = 0; j < NBITS; j++) begin : g_flip
    localparam logic [7:0] EBIT = 8'(1 << j);
    dfa_sbox u_sflip (.a_i(x_i ^ EBIT), .y_o(sflip[j]));
    assign diff_o[j] = sx_o ^ sflip[j];
  end

endmodule

// File: rtl/dfa_ctrl.sv
module dfa_ctrl
  import dfa_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pair_valid,
  output logic       ready_o,
  output logic       capture_o,
  output logic       scan_o,
  output logic       merge_o,
  output logic [7:0] x_o
);

  localparam int BUSY_CYCLES = NVAL + 1;
  localparam int BW = $clog2(BUSY_CYCLES + 2);

  phase_t     phase_q;
  logic [7:0] x_q;
  logic       ready_q;

  assign capture_o = (phase_q == PH_IDLE) && pair_valid;
  assign scan_o    = (phase_q == PH_SCAN);
  assign merge_o   = (phase_q == PH_MERGE);
  assign x_o       = x_q;
  assign ready_o   = ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      x_q     <= 8'h00;
      ready_q <= 1'b1;
    end else begin
      case (phase_q)
        PH_IDLE: if (pair_valid) begin
          phase_q <= PH_SCAN;
          x_q     <= 8'h00;
          ready_q <= 1'b0;
        end
        PH_SCAN: begin
          x_q <= x_q + 8'd1;
          if (x_q == 8'hFF) phase_q <= PH_MERGE;
        end
        PH_MERGE: begin
          phase_q <= PH_IDLE;
          ready_q <= 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // busy-window length, counted independently of the phase register
  logic [BW-1:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst)                       busy_cnt <= '0;
    else if (capture_o)            busy_cnt <= '0;
    else if (!ready_q)             busy_cnt <= busy_cnt + 1'b1;
  end

  assert_accept_drops_ready_R3: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && ready_q) |=> !ready_q);

  assert_busy_span_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_q) |-> (busy_cnt == BW'(BUSY_CYCLES)));

endmodule

// File: rtl/dfa_lane.sv
module dfa_lane
  import dfa_pkg::*;
#(
  parameter int MAX_SETS = 4,
  parameter int NBITS    = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  capture_i,
  input  logic                  scan_i,
  input  logic                  merge_i,
  input  logic [7:0]            good_i,
  input  logic [7:0]            bad_i,
  input  logic [7:0]            sx_i,
  input  logic [NBITS-1:0][7:0] diff_i,
  output logic [1:0]            class_o,
  output logic                  key_valid_o,
  output logic [7:0]            key_o,
  output logic                  unres_o
);

  localparam int SW = $clog2(MAX_SETS + 1);

  logic [7:0]      good_q;
  logic [7:0]      delta_q;
  fclass_t         cls_q;
  logic [NVAL-1:0] cand_q;
  logic [NVAL-1:0] acc_q;
  logic [SW-1:0]   nsets_q;
  logic            kv_q;
  logic [7:0]      key_q;
  logic            un_q;

  logic            hit;
  logic            active;
  logic            frozen;
  logic [NVAL-1:0] inter;
  logic [NVAL-1:0] nxt;
  logic            single;
  logic [7:0]      enc;

  assign active = (cls_q != FC_NONE);
  assign frozen = kv_q | un_q;

  always_comb begin
    hit = 1'b0;
    for (int j = 0; j < NBITS; j++)
      if (diff_i[j] == delta_q) hit = 1'b1;
  end

  always_comb begin
    inter = acc_q & cand_q;
    if (nsets_q == '0)  nxt = cand_q;
    else if (|inter)    nxt = inter;
    else                nxt = acc_q | cand_q;
    single = (|nxt) && ((nxt & (nxt - 1'b1)) == '0);
    enc = 8'h00;
    for (int i = 0; i < NVAL; i++)
      if (nxt[i]) enc = 8'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      good_q  <= 8'h00;
      delta_q <= 8'h00;
      cls_q   <= FC_NONE;
      cand_q  <= '0;
      acc_q   <= '0;
      nsets_q <= '0;
      kv_q    <= 1'b0;
      key_q   <= 8'h00;
      un_q    <= 1'b0;
    end else begin
      if (capture_i) begin
        good_q  <= good_i;
        delta_q <= good_i ^ bad_i;
        cls_q   <= weigh(good_i ^ bad_i);
        cand_q  <= '0;
      end else if (scan_i && active && hit) begin
        cand_q[good_q ^ sx_i] <= 1'b1;
      end
      if (merge_i && active && !frozen) begin
        acc_q   <= nxt;
        nsets_q <= nsets_q + 1'b1;
        if (single) begin
          kv_q  <= 1'b1;
          key_q <= enc;
        end else if (nsets_q == SW'(MAX_SETS - 1)) begin
          un_q  <= 1'b1;
        end
      end
    end
  end

  assign class_o     = cls_q;
  assign key_valid_o = kv_q;
  assign key_o       = key_q;
  assign unres_o     = un_q;

  assert_key_hold_R7: assert property (@(posedge clk) disable iff (rst)
    kv_q |=> (kv_q && $stable(key_q)));

  assert_key_after_merge_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(kv_q) |-> $past(merge_i));

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(kv_q && un_q));

  assert_unres_at_limit_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(un_q) |-> (nsets_q == SW'(MAX_SETS)));

  assert_set_moves_on_merge_R6: assert property (@(posedge clk) disable iff (rst)
    !merge_i |=> $stable(acc_q));

  assert_quiet_lane_R5: assert property (@(posedge clk) disable iff (rst)
    (scan_i && (cls_q == FC_NONE)) |=> $stable(cand_q));

  assert_key_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !kv_q |-> (key_q == 8'h00));

endmodule

// File: rtl/dfa_keybyte_solver.sv
module dfa_keybyte_solver
  import dfa_pkg::*;
#(
  parameter int NBYTES   = 16,
  parameter int MAX_SETS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pair_valid,
  output logic                  pair_ready,
  input  logic [8*NBYTES-1:0]   ct_good,
  input  logic [8*NBYTES-1:0]   ct_bad,
  output logic [2*NBYTES-1:0]   fault_class,
  output logic [NBYTES-1:0]     key_valid,
  output logic [8*NBYTES-1:0]   key_byte,
  output logic [NBYTES-1:0]     unresolved
);

  localparam int NBITS = BYTE_W;

  logic                  capture;
  logic                  scan;
  logic                  merge;
  logic [7:0]            x;
  logic [7:0]            sx;
  logic [NBITS-1:0][7:0] diff;

  dfa_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .pair_valid(pair_valid),
    .ready_o   (pair_ready),
    .capture_o (capture),
    .scan_o    (scan),
    .merge_o   (merge),
    .x_o       (x)
  );

  // one shared probe: the scanned state value is common to all lanes
  dfa_probe #(.NBITS(NBITS)) u_probe (
    .x_i   (x),
    .sx_o  (sx),
    .diff_o(diff)
  );

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    dfa_lane #(.MAX_SETS(MAX_SETS), .NBITS(NBITS)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .capture_i  (capture),
      .scan_i     (scan),
      .merge_i    (merge),
      .good_i     (ct_good[8*i +: 8]),
      .bad_i      (ct_bad[8*i +: 8]),
      .sx_i       (sx),
      .diff_i     (diff),
      .class_o    (fault_class[2*i +: 2]),
      .key_valid_o(key_valid[i]),
      .key_o      (key_byte[8*i +: 8]),
      .unres_o    (unresolved[i])
    );
  end

endmodule

// File: tb/dfa_keybyte_solver_tb.sv
module dfa_keybyte_solver_tb;

  localparam int NB = 4;
  localparam int MS = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              pair_valid = 1'b0;
  logic              pair_ready;
  logic [8*NB-1:0]   ct_good = '0;
  logic [8*NB-1:0]   ct_bad = '0;
  logic [2*NB-1:0]   fault_class;
  logic [NB-1:0]     key_valid;
  logic [8*NB-1:0]   key_byte;
  logic [NB-1:0]     unresolved;

  dfa_keybyte_solver #(.NBYTES(NB), .MAX_SETS(MS)) u_dut (
    .clk(clk), .rst(rst), .pair_valid(pair_valid), .pair_ready(pair_ready),
    .ct_good(ct_good), .ct_bad(ct_bad), .fault_class(fault_class),
    .key_valid(key_valid), .key_byte(key_byte), .unresolved(unresolved)
  );

  always #10 clk = ~clk;

  int nvec = 0;
  int nfail = 0;
  int cyc = 0;
  bit finished = 0;

  logic [7:0] sb [256];
  bit [255:0] m_acc [NB];
  int         m_n   [NB];
  bit         m_kv  [NB];
  bit         m_un  [NB];
  logic [7:0] m_key [NB];
  logic [7:0] keys  [NB];

  function automatic logic [7:0] tmul(input logic [7:0] a, input logic [7:0] b);
    int r = 0;
    int aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ aa;
      aa = aa << 1;
      if (aa > 255) aa = aa ^ 'h11b;
    end
    return 8'(r);
  endfunction

  task automatic build_sbox();
    for (int v = 0; v < 256; v++) begin
      logic [7:0] inv = 8'h00;
      logic [7:0] y;
      if (v != 0)
        for (int w = 1; w < 256; w++)
          if (tmul(8'(v), 8'(w)) == 8'h01) inv = 8'(w);
      for (int i = 0; i < 8; i++)
        y[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8]
               ^ ((8'h63 >> i) & 1);
      sb[v] = y;
    end
  endtask

  task automatic check(input string tag, input int lane, input logic [31:0] act,
                       input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s lane %0d: actual %0h expected %0h", tag, lane, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int l = 0; l < NB; l++) begin
      m_acc[l] = '0; m_n[l] = 0; m_kv[l] = 0; m_un[l] = 0; m_key[l] = 8'h00;
    end
  endtask

  // reference campaign model, written from the requirements (R4..R8)
  task automatic model_pair(input logic [8*NB-1:0] g, input logic [8*NB-1:0] b);
    for (int l = 0; l < NB; l++) begin
      logic [7:0] gl = g[8*l +: 8];
      logic [7:0] d  = gl ^ b[8*l +: 8];
      bit [255:0] ns = '0;
      bit [255:0] res;
      if (d == 8'h00 || m_kv[l] || m_un[l]) continue;
      for (int v = 0; v < 256; v++)
        for (int j = 0; j < 8; j++)
          if ((sb[v] ^ sb[v ^ (1 << j)]) == d) ns[gl ^ sb[v]] = 1'b1;
      if (m_n[l] == 0)                  res = ns;
      else if ((m_acc[l] & ns) != '0)   res = m_acc[l] & ns;
      else                              res = m_acc[l] | ns;
      m_acc[l] = res;
      m_n[l]++;
      if ($countones(res) == 1) begin
        m_kv[l] = 1;
        for (int k = 0; k < 256; k++) if (res[k]) m_key[l] = 8'(k);
      end else if (m_n[l] == MS) begin
        m_un[l] = 1;
      end
    end
  endtask

  function automatic logic [1:0] exp_class(input logic [7:0] d);
    int w = $countones(d);
    return (w >= 3) ? 2'd3 : 2'(w);
  endfunction

  task automatic check_outputs();
    for (int l = 0; l < NB; l++) begin
      check("R7 key_valid", l, key_valid[l], m_kv[l]);
      check("R4 R6 R10 key_byte", l, key_byte[8*l +: 8], m_kv[l] ? m_key[l] : 8'h00);
      check("R8 unresolved", l, unresolved[l], m_un[l]);
    end
  endtask

  task automatic send_pair(input logic [8*NB-1:0] g, input logic [8*NB-1:0] b,
                           input bit junk);
    int low;
    @(negedge clk);
    while (!pair_ready) @(negedge clk);
    ct_good = g; ct_bad = b; pair_valid = 1'b1;
    @(negedge clk);
    pair_valid = 1'b0;
    // R2 R9: each lane's class from its own bytes only
    for (int l = 0; l < NB; l++)
      check("R2 R9 fault_class", l, fault_class[2*l +: 2],
            exp_class(g[8*l +: 8] ^ b[8*l +: 8]));
    low = pair_ready ? 0 : 1;
    if (junk) begin
      // R3: offered while busy, must be ignored
      for (int k = 0; k < 20; k++) begin
        ct_good = ~g; ct_bad = g; pair_valid = 1'b1;
        @(negedge clk);
        if (!pair_ready) low++;
      end
      pair_valid = 1'b0;
      ct_good = g; ct_bad = b;
    end
    while (1) begin
      @(negedge clk);
      if (pair_ready) break;
      low++;
    end
    check("R3 busy cycles", 0, low, 257);
    if (junk)
      for (int l = 0; l < NB; l++)
        check("R3 class after junk", l, fault_class[2*l +: 2],
              exp_class(g[8*l +: 8] ^ b[8*l +: 8]));
    model_pair(g, b);
    check_outputs();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    pair_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    model_reset();
    check("R1 ready", 0, pair_ready, 1);
    for (int l = 0; l < NB; l++) begin
      check("R1 key_valid", l, key_valid[l], 0);
      check("R1 R10 key_byte", l, key_byte[8*l +: 8], 0);
      check("R1 unresolved", l, unresolved[l], 0);
      check("R1 class", l, fault_class[2*l +: 2], 0);
    end
  endtask

  // kind: 0 no fault (R5), 1 one-bit state fault, 2 two-bit state fault, 3 wrong pair
  task automatic make_lane(input int kind, input logic [7:0] k, input logic [7:0] m,
                           input int j, output logic [7:0] g, output logic [7:0] b);
    g = sb[m] ^ k;
    case (kind)
      0: b = g;
      1: b = sb[m ^ 8'(1 << j)] ^ k;
      2: b = sb[m ^ 8'(3 << (j % 7))] ^ k;
      default: b = g ^ 8'h5b;
    endcase
  endtask

  initial begin
    logic [8*NB-1:0] g, b;
    build_sbox();
    keys[0] = 8'h25; keys[1] = 8'ha7; keys[2] = 8'h3c; keys[3] = 8'he1;
    do_reset();

    // campaign with mixed lane behaviour (R4 R5 R6 R7 R9)
    for (int p = 0; p < 8; p++) begin
      for (int l = 0; l < NB; l++) begin
        int kind;
        logic [7:0] gl, bl;
        case (l)
          0: kind = 1;
          1: kind = (p % 2 == 0) ? 0 : 1;
          2: kind = (p == 0) ? 2 : 1;
          default: kind = (p == 3) ? 3 : 1;
        endcase
        make_lane(kind, keys[l], 8'(p*53 + l*101 + 7), (p*3 + l) % 8, gl, bl);
        g[8*l +: 8] = gl; b[8*l +: 8] = bl;
      end
      send_pair(g, b, p == 2);
    end

    // repeated identical pair never narrows below two candidates (R8), lane 3 unfaulted (R5)
    do_reset();
    for (int p = 0; p < 7; p++) begin
      for (int l = 0; l < NB; l++) begin
        logic [7:0] gl, bl;
        make_lane((l == 3) ? 0 : 1, keys[l], 8'(l*29 + 11), l + 2, gl, bl);
        g[8*l +: 8] = gl; b[8*l +: 8] = bl;
      end
      send_pair(g, b, 1'b0);
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      nvec++;
      nfail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule